// File: doc/BRIEF.md
# Staged Filter Coefficient Loader

This block is a small register-bus slave that fills a polyphase anti-alias filter coefficient bank. Software never writes a coefficient slot directly. It first fills a set of staging words, then writes a commit address. The commit copies all staging words at once into the slot picked by an internal phase pointer and moves the pointer on by one. Filling all sixteen phases therefore takes sixteen stage-then-commit rounds.

Each instance serves one filter on one plane. Luma and chroma each get their own instance, so their staging words and commit strobes stay independent. The number of staging words is a parameter. The horizontal filter uses five staging words and the vertical filter uses two. The filter datapath reads any phase through a combinational read port. A bank-valid flag tells the datapath when every phase has been committed since the last pointer restart.

A commit is accepted only when every staging word has been written since the previous accepted commit. A commit that arrives too early is dropped and raises a sticky sequence-error flag.

Top module: `coef_stage_loader`

## Requirements
- R1: After reset the phase pointer is 0, bank_valid is 0, seq_err is 0 and every phase reads back all zeros.
- R2: A write to address k, with k from 0 to NSTAGE-1, holds staging word k. An accepted commit places word k at bits [k*WORD_W +: WORD_W] of the committed row.
- R3: A commit is a write to address NSTAGE. It is accepted when all staging words have been written. It stores the staged row into the slot at the current phase pointer and increments the pointer, wrapping from NPHASE-1 to 0.
- R4: A commit that arrives while any staging word is unwritten leaves the bank and the phase pointer unchanged and sets seq_err.
- R5: The written flags of all staging words clear after every accepted commit, so a repeated commit without fresh staging writes is rejected.
- R6: bank_valid rises on the cycle after the commit to phase NPHASE-1. It then stays high, including across the pointer wrap, until a pointer restart.
- R7: A write to address NSTAGE+1 with bit 0 set restarts the pointer at 0 and clears bank_valid. The same write with bit 1 set clears seq_err. seq_err otherwise holds its value.
- R8: The data written with a commit is ignored. Writes to addresses above NSTAGE+1 change no output and no state.
- R9: rd_coef shows the stored row of rd_phase combinationally, so a committed phase is visible on the cycle after its commit.
- R10: An instance with NSTAGE=2 follows the same rules, with its commit at address 2 and its control at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: staging words, then commit, then control |
| wr_data | input | WORD_W | Write data |
| rd_phase | input | $clog2(NPHASE) | Phase selected for the coefficient read port |
| rd_coef | output | NSTAGE*WORD_W | Stored coefficient row of rd_phase |
| phase | output | $clog2(NPHASE) | Current phase pointer |
| bank_valid | output | 1 | All phases committed since the last restart |
| seq_err | output | 1 | Sticky flag for a rejected commit |

## Verification
The assertions assume that the bus issues at most one write per cycle and that wr_addr has a defined value whenever wr_en is high. They also assume that rst_n is asserted before the first clock edge, so that every $past comparison starts from reset values. The bench drives one write per bus cycle from a fixed-seed random mix of staging writes, commits, control writes and unmapped writes, with wr_en low between them. It resets both instances at time zero, which keeps the stimulus inside these assumptions.

// File: rtl/coef_stage_loader.sv
module coef_stage_loader #(
  parameter int NSTAGE = 5,
  parameter int WORD_W = 16,
  parameter int NPHASE = 16,
  parameter int ADDR_W = 4,
  localparam int PH_W  = $clog2(NPHASE),
  localparam int ROW_W = NSTAGE * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [PH_W-1:0]   rd_phase,
  output logic [ROW_W-1:0]  rd_coef,
  output logic [PH_W-1:0]   phase,
  output logic              bank_valid,
  output logic              seq_err
);

  logic [NSTAGE-1:0][WORD_W-1:0] stage_q;
  logic [NSTAGE-1:0]             seen_q;
  logic [NPHASE-1:0][ROW_W-1:0]  bank_q;
  logic [PH_W-1:0]               phase_q;
  logic                          valid_q;
  logic                          err_q;

  wire hit_trig = wr_en && (wr_addr == ADDR_W'(NSTAGE));
  wire hit_ctrl = wr_en && (wr_addr == ADDR_W'(NSTAGE + 1));
  wire all_seen = &seen_q;
  wire commit   = hit_trig && all_seen;
  wire restart  = hit_ctrl && wr_data[0];
  wire err_clr  = hit_ctrl && wr_data[1];
  wire last_ph  = (phase_q == PH_W'(NPHASE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      for (int k = 0; k < NSTAGE; k++)
        if (wr_en && wr_addr == ADDR_W'(k)) stage_q[k] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (commit) begin
      seen_q <= '0;
    end else begin
      for (int k = 0; k < NSTAGE; k++)
        if (wr_en && wr_addr == ADDR_W'(k)) seen_q[k] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bank_q <= '0;
    else if (commit) bank_q[phase_q] <= stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (commit)  phase_q <= last_ph ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  valid_q <= 1'b0;
    else if (restart)            valid_q <= 1'b0;
    else if (commit && last_ph)  valid_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       err_q <= 1'b0;
    else if (hit_trig && !all_seen)   err_q <= 1'b1;
    else if (err_clr)                 err_q <= 1'b0;
  end

  assign rd_coef    = bank_q[rd_phase];
  assign phase      = phase_q;
  assign bank_valid = valid_q;
  assign seq_err    = err_q;

  p_phase_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_trig || hit_ctrl) |=> $stable(phase_q));

  p_bank_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(bank_q));

  p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_trig && !all_seen) |=> (err_q && $stable(phase_q) && $stable(bank_q)));

  p_flags_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (seen_q == '0));

  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !restart) |=> valid_q);

  p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> ($past(phase_q) == PH_W'(NPHASE - 1)));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);

endmodule

// File: tb/coef_stage_loader_bench.sv
module coef_stage_loader_bench;
  localparam int NS = 5, WW = 16, NP = 16, AW = 4, PW = 4, RW = NS * WW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic [PW-1:0] rd_phase = '0;
  logic [RW-1:0] rd_coef;
  logic [PW-1:0] phase;
  logic          bank_valid, seq_err;

  coef_stage_loader #(.NSTAGE(NS), .WORD_W(WW), .NPHASE(NP), .ADDR_W(AW)) u_coef_stage_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_phase(rd_phase), .rd_coef(rd_coef), .phase(phase),
    .bank_valid(bank_valid), .seq_err(seq_err));

  logic          v_wr_en = 1'b0;
  logic [AW-1:0] v_wr_addr = '0;
  logic [WW-1:0] v_wr_data = '0;
  logic [PW-1:0] v_rd_phase = '0;
  logic [2*WW-1:0] v_rd_coef;
  logic [PW-1:0] v_phase;
  logic          v_valid, v_err;

  coef_stage_loader #(.NSTAGE(2), .WORD_W(WW), .NPHASE(NP), .ADDR_W(AW)) u_coef_stage_loader_vert (
    .clk(clk), .rst_n(rst_n), .wr_en(v_wr_en), .wr_addr(v_wr_addr), .wr_data(v_wr_data),
    .rd_phase(v_rd_phase), .rd_coef(v_rd_coef), .phase(v_phase),
    .bank_valid(v_valid), .seq_err(v_err));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [WW-1:0] m_stage [NS];
  logic [NS-1:0] m_seen;
  logic [RW-1:0] m_bank [NP];
  logic [PW-1:0] m_phase;
  logic          m_valid, m_err;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] staged_row();
    logic [RW-1:0] r;
    for (int k = 0; k < NS; k++) r[k*WW +: WW] = m_stage[k];
    return r;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NS; k++) m_stage[k] = '0;
    for (int p = 0; p < NP; p++) m_bank[p] = '0;
    m_seen = '0; m_phase = '0; m_valid = 1'b0; m_err = 1'b0;
  endtask

  task automatic model_write(input int a, input logic [WW-1:0] d);
    if (a < NS) begin
      m_stage[a] = d; m_seen[a] = 1'b1;
    end else if (a == NS) begin
      if (&m_seen) begin
        m_bank[m_phase] = staged_row();
        if (m_phase == PW'(NP - 1)) m_valid = 1'b1;
        m_phase = m_phase + 1'b1;
        m_seen = '0;
      end else m_err = 1'b1;
    end else if (a == NS + 1) begin
      if (d[0]) begin m_phase = '0; m_valid = 1'b0; end
      if (d[1]) m_err = 1'b0;
    end
  endtask

  task automatic bus(input int a, input logic [WW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic check_state(input string tag);
    chk({tag, " R3 phase"}, 128'(phase), 128'(m_phase));
    chk({tag, " R6 bank_valid"}, 128'(bank_valid), 128'(m_valid));
    chk({tag, " R7 seq_err"}, 128'(seq_err), 128'(m_err));
  endtask

  task automatic check_row(input string tag, input int p);
    rd_phase = PW'(p);
    #0.5;
    chk({tag, " R9 rd_coef"}, 128'(rd_coef), 128'(m_bank[p]));
  endtask

  task automatic stage_all(input logic [WW-1:0] base);
    for (int k = 0; k < NS; k++) bus(k, base + WW'(k));
  endtask

  task automatic vbus(input int a, input logic [WW-1:0] d);
    @(negedge clk);
    v_wr_en = 1'b1; v_wr_addr = AW'(a); v_wr_data = d;
    @(negedge clk);
    v_wr_en = 1'b0;
  endtask

  initial begin
    void'($urandom(1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check_state("reset R1");
    for (int p = 0; p < NP; p++) check_row("reset R1", p);

    // R4: commit with nothing staged is rejected
    bus(NS, 16'h1234);
    check_state("early commit R4");
    check_row("early commit R4", 0);
    bus(NS + 1, 16'h0002);
    check_state("err clear R7");

    // R2/R3/R9: first commit, visible the cycle after
    stage_all(16'hA000);
    bus(NS, 16'hFFFF);
    check_row("first commit R2", 0);
    chk("R2 word 3 position", 128'(rd_coef[3*WW +: WW]), 128'(16'hA003));
    check_state("first commit R3");

    // R5: repeat commit without restaging
    bus(NS, 16'h0000);
    check_state("repeat commit R5");
    chk("R5 repeat rejected", 128'(seq_err), 128'(1'b1));
    bus(NS + 1, 16'h0002);

    // R4: one word missing
    for (int k = 0; k < NS - 1; k++) bus(k, 16'h5500 + WW'(k));
    bus(NS, 16'h0);
    check_state("partial stage R4");
    check_row("partial stage R4", 1);
    bus(NS - 1, 16'h55FF);
    bus(NS, 16'h0);
    check_row("completed stage R2", 1);

    // R8: unmapped writes
    for (int a = NS + 2; a < 16; a++) bus(a, 16'hDEAD);
    check_state("unmapped R8");
    check_row("unmapped R8", 1);

    // R6: fill to last phase
    for (int p = 2; p < NP; p++) begin
      stage_all(WW'(p << 8));
      bus(NS, 16'h0);
      if (p == NP - 2) chk("R6 not yet valid", 128'(bank_valid), 128'(1'b0));
    end
    chk("R6 valid after last phase", 128'(bank_valid), 128'(1'b1));
    chk("R3 wrap to 0", 128'(phase), 128'(0));
    stage_all(16'hC000);
    bus(NS, 16'h0);
    chk("R6 valid held across wrap", 128'(bank_valid), 128'(1'b1));
    check_row("wrap overwrite R3", 0);
    bus(NS + 1, 16'h0001);
    check_state("restart R7");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r, a;
      r = $urandom_range(0, 99);
      if (r < 60)      bus($urandom_range(0, NS - 1), WW'($urandom));
      else if (r < 76) bus(NS, WW'($urandom));
      else if (r < 80) bus(NS + 1, WW'($urandom_range(0, 3)));
      else if (r < 86) begin a = $urandom_range(NS + 2, 15); bus(a, WW'($urandom)); end
      else @(negedge clk);
      check_state("random");
      check_row("random", $urandom_range(0, NP - 1));
    end

    // R10: two-word vertical instance
    vbus(2, 16'h0);
    chk("R10 vertical early commit", 128'(v_err), 128'(1'b1));
    chk("R10 vertical phase held", 128'(v_phase), 128'(0));
    vbus(0, 16'h1111);
    vbus(1, 16'h2222);
    vbus(2, 16'h0);
    v_rd_phase = '0;
    #0.5;
    chk("R10 vertical row", 128'(v_rd_coef), 128'(32'h2222_1111));
    chk("R10 vertical phase", 128'(v_phase), 128'(1));
    vbus(3, 16'h0003);
    chk("R10 vertical restart", 128'(v_phase), 128'(0));
    chk("R10 vertical err clear", 128'(v_err), 128'(0));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule